// File: doc/BRIEF.md
# NAND access adapter

This block sits behind a chip-select register window and turns processor register accesses into NAND bus cycles. Each chip select has its own block of registers. Three of them drive the NAND bus: a command register, an address register and a data register. A write to the command register produces cycles with the command latch asserted. A write to the address register produces cycles with the address latch asserted. Reads and writes of the data register produce plain data cycles.

A processor access may be 8, 16 or 32 bits wide. The adapter splits it into byte cycles for an 8-bit device, or halfword cycles for a 16-bit device, always starting with the least significant part. For reads it puts the returned pieces back together in the same order. A chip select whose configured type is not NAND ignores these registers: writes have no effect and reads return zero.

The processor side is a valid/ready request stream. `req_ready` is high only while the adapter is idle, so a request that is held valid waits until every device cycle of the previous access has finished. The response is a one-cycle `rsp_valid` pulse with no back-pressure. The device side is a valid/ready cycle stream: each cycle holds `dev_valid` and all its fields steady until the device raises `dev_ready`. For a read cycle, `dev_rdata` is sampled on that same handshake edge.

Top module: `nand_access_adapter`

## Requirements
- R1: Chip select `c` has a register block at byte offset 0x60 + 0x30*c. Inside it the command register is at +0x1c, the address register at +0x20 and the data register at +0x24. Any of the four byte addresses of a register selects that register. `dev_cs` carries `c` for every device cycle of the access.
- R2: Two bits per chip select in `cs_type` give its device type, bits [2c+1:2c] for chip select `c`, and the value 2 means NAND. For any other type, a write to a NAND register issues no device cycle, and a read of one issues no device cycle and returns zero.
- R3: Command-register writes issue cycles with `dev_cle`=1 and `dev_ale`=0. Address-register writes issue cycles with `dev_ale`=1 and `dev_cle`=0. Data-register accesses issue cycles with both latches at 0. The checker also requires that no device cycle ever has both latches high.
- R4: When `cs_wide[c]`=0 the device is 8 bits wide. A write then issues 1, 2 or 4 byte cycles for a byte, halfword or word access, least significant byte first. Each cycle carries its byte on `dev_wdata[7:0]` with `dev_wdata[15:8]`=0.
- R5: When `cs_wide[c]`=1 the device is 16 bits wide. A byte or halfword write issues one cycle carrying `req_wdata[15:0]`. A word write issues two cycles: `req_wdata[15:0]` first, then `req_wdata[31:16]`.
- R6: Reads from an 8-bit device place the byte of cycle k (taken from `dev_rdata[7:0]`) at bits [8k+7:8k]. Reads from a 16-bit device place the halfword of cycle k at bits [16k+15:16k]. A byte read from a 16-bit device returns only `dev_rdata[7:0]` of its single cycle. All bits above the access size read as zero.
- R7: `req_size` encodes 0 as byte, 1 as halfword, and both 2 and 3 as word.
- R8: `req_ready` is high only while idle, and a request is taken on `req_valid && req_ready`. Each device cycle keeps `dev_valid` and its fields stable until `dev_ready`. `rsp_valid` pulses for one cycle: in the cycle after the final device handshake, or in the cycle after acceptance when no device cycle is issued.
- R9: Reads of the command or address register, and any access to an offset outside the three NAND registers, issue no device cycle and return zero.
- R10: During and directly after reset `req_ready`=1, `dev_valid`=0 and `rsp_valid`=0. This holds even if the reset arrives in the middle of a device access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_type | input | 2*NUM_CS | Device type per chip select, 2 = NAND |
| cs_wide | input | NUM_CS | Device width per chip select, 1 = 16-bit |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Adapter idle, request taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the register window |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, zero for writes |
| dev_valid | output | 1 | NAND bus cycle pending |
| dev_ready | input | 1 | Device completes the pending cycle |
| dev_cs | output | CS_W | Chip select of the cycle |
| dev_cle | output | 1 | Command latch enable |
| dev_ale | output | 1 | Address latch enable |
| dev_write | output | 1 | 1 = write cycle |
| dev_wdata | output | 16 | Cycle write data |
| dev_rdata | input | 16 | Cycle read data, sampled at handshake |

## Verification
The request is taken on the edge after the bench raises `req_valid`. The first device cycle then shows on `dev_valid` one cycle later, or `rsp_valid` shows there directly when no bus cycle is due. `rsp_valid` follows the last `dev_ready` handshake by exactly one cycle. The bench drives inputs and samples outputs only at falling edges. It numbers the cycles after acceptance, records the index of every handshake, and requires the response to fall on the index one past the final handshake. A stalled run lowers `dev_ready` on alternate cycles, to show that the pending cycle holds still and that the response latency shifts by the number of stalls.

// File: rtl/nacc_pkg.sv
`timescale 1ns/1ps
package nacc_pkg;
  localparam int unsigned HOST_W = 32;
  localparam int unsigned DEV_W  = 16;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_CMD  = 2'd1,
    RK_ADR  = 2'd2,
    RK_DAT  = 2'd3
  } reg_kind_t;

  localparam logic [1:0] SZ_BYTE   = 2'd0;
  localparam logic [1:0] SZ_HALF   = 2'd1;
  localparam logic [1:0] TYPE_NAND = 2'd2;
endpackage

// File: rtl/nacc_decode.sv
`timescale 1ns/1ps
module nacc_decode
  import nacc_pkg::*;
#(
  parameter int unsigned NUM_CS    = 8,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned CS_BASE   = 'h60,
  parameter int unsigned CS_STRIDE = 'h30,
  parameter int unsigned OFS_CMD   = 'h1c,
  parameter int unsigned OFS_ADR   = 'h20,
  parameter int unsigned OFS_DAT   = 'h24,
  localparam int unsigned CS_W     = $clog2(NUM_CS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_kind_t         kind,
  output logic [CS_W-1:0]   cs
);
  logic [NUM_CS-1:0] m_cmd, m_adr, m_dat;

  // one word-aligned comparator per register per chip select
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(CS_BASE + g*CS_STRIDE + OFS_CMD);
    localparam logic [ADDR_W-1:0] A_ADR = ADDR_W'(CS_BASE + g*CS_STRIDE + OFS_ADR);
    localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(CS_BASE + g*CS_STRIDE + OFS_DAT);
    assign m_cmd[g] = (addr >> 2) == (A_CMD >> 2);
    assign m_adr[g] = (addr >> 2) == (A_ADR >> 2);
    assign m_dat[g] = (addr >> 2) == (A_DAT >> 2);
  end

  always_comb begin
    hit  = 1'b0;
    kind = RK_NONE;
    cs   = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (m_cmd[i] || m_adr[i] || m_dat[i]) begin
        hit  = 1'b1;
        cs   = CS_W'(i);
        kind = m_cmd[i] ? RK_CMD : (m_adr[i] ? RK_ADR : RK_DAT);
      end
    end
  end
endmodule

// File: rtl/nacc_beats.sv
`timescale 1ns/1ps
module nacc_beats
  import nacc_pkg::*;
(
  input  logic [1:0]        size,
  input  logic              wide,
  input  logic [1:0]        beat,
  input  logic [HOST_W-1:0] wdata,
  input  logic [DEV_W-1:0]  rdata,
  input  logic [HOST_W-1:0] acc,
  output logic              last,
  output logic [DEV_W-1:0]  beat_wdata,
  output logic [HOST_W-1:0] acc_next
);
  logic [2:0]        count;
  logic [HOST_W-1:0] slice;
  logic [4:0]        shamt;

  always_comb begin
    if (wide) begin
      count      = size[1] ? 3'd2 : 3'd1;
      beat_wdata = beat[0] ? wdata[31:16] : wdata[15:0];
      slice      = (size == SZ_BYTE) ? {24'h0, rdata[7:0]} : {16'h0, rdata};
      shamt      = {beat[0], 4'b0000};
    end else begin
      case (size)
        SZ_BYTE: count = 3'd1;
        SZ_HALF: count = 3'd2;
        default: count = 3'd4;
      endcase
      beat_wdata = {8'h00, wdata[{beat, 3'b000} +: 8]};
      slice      = {24'h0, rdata[7:0]};
      shamt      = {beat, 3'b000};
    end
    last     = ({1'b0, beat} == (count - 3'd1));
    acc_next = acc | (slice << shamt);
  end
endmodule

// File: rtl/nacc_seq.sv
`timescale 1ns/1ps
module nacc_seq
  import nacc_pkg::*;
#(
  parameter int unsigned CS_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [HOST_W-1:0] req_wdata,
  input  logic              go_bus,
  input  reg_kind_t         kind,
  input  logic [CS_W-1:0]   cs,
  input  logic              wide,
  output logic              rsp_valid,
  output logic [HOST_W-1:0] rsp_rdata,
  output logic              dev_valid,
  input  logic              dev_ready,
  output logic [CS_W-1:0]   dev_cs,
  output logic              dev_cle,
  output logic              dev_ale,
  output logic              dev_write,
  output logic [DEV_W-1:0]  dev_wdata,
  input  logic [DEV_W-1:0]  dev_rdata
);
  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_RESP} st_t;

  st_t               st;
  logic              op_write, op_wide;
  reg_kind_t         op_kind;
  logic [CS_W-1:0]   op_cs;
  logic [1:0]        op_size, beat;
  logic [HOST_W-1:0] op_wdata, rd_acc;

  logic              plan_last;
  logic [DEV_W-1:0]  plan_wd;
  logic [HOST_W-1:0] plan_acc;

  nacc_beats u_plan (
    .size      (op_size),
    .wide      (op_wide),
    .beat      (beat),
    .wdata     (op_wdata),
    .rdata     (dev_rdata),
    .acc       (rd_acc),
    .last      (plan_last),
    .beat_wdata(plan_wd),
    .acc_next  (plan_acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      op_write <= 1'b0;
      op_wide  <= 1'b0;
      op_kind  <= RK_NONE;
      op_cs    <= '0;
      op_size  <= '0;
      op_wdata <= '0;
      beat     <= '0;
      rd_acc   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          op_write <= req_write;
          op_wide  <= wide;
          op_kind  <= kind;
          op_cs    <= cs;
          op_size  <= req_size;
          op_wdata <= req_wdata;
          beat     <= '0;
          rd_acc   <= '0;
          st       <= go_bus ? ST_BUS : ST_RESP;
        end
        ST_BUS: if (dev_ready) begin
          if (!op_write) rd_acc <= plan_acc;
          if (plan_last) st <= ST_RESP;
          else           beat <= beat + 2'd1;
        end
        ST_RESP: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (st == ST_IDLE);
    dev_valid = (st == ST_BUS);
    dev_cle   = dev_valid && (op_kind == RK_CMD);
    dev_ale   = dev_valid && (op_kind == RK_ADR);
    dev_write = dev_valid && op_write;
    dev_cs    = op_cs;
    dev_wdata = (dev_valid && op_write) ? plan_wd : '0;
    rsp_valid = (st == ST_RESP);
    rsp_rdata = rd_acc;
  end
endmodule

// File: rtl/nand_access_adapter.sv
`timescale 1ns/1ps
module nand_access_adapter
  import nacc_pkg::*;
#(
  parameter int unsigned NUM_CS    = 8,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned CS_BASE   = 'h60,
  parameter int unsigned CS_STRIDE = 'h30,
  parameter int unsigned OFS_CMD   = 'h1c,
  parameter int unsigned OFS_ADR   = 'h20,
  parameter int unsigned OFS_DAT   = 'h24,
  localparam int unsigned CS_W     = $clog2(NUM_CS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*NUM_CS-1:0] cs_type,
  input  logic [NUM_CS-1:0]   cs_wide,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  output logic [31:0]         rsp_rdata,
  output logic                dev_valid,
  input  logic                dev_ready,
  output logic [CS_W-1:0]     dev_cs,
  output logic                dev_cle,
  output logic                dev_ale,
  output logic                dev_write,
  output logic [15:0]         dev_wdata,
  input  logic [15:0]         dev_rdata
);
  logic            d_hit;
  reg_kind_t       d_kind;
  logic [CS_W-1:0] d_cs;
  logic            is_nand, go_bus;

  nacc_decode #(
    .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .CS_BASE(CS_BASE), .CS_STRIDE(CS_STRIDE),
    .OFS_CMD(OFS_CMD), .OFS_ADR(OFS_ADR), .OFS_DAT(OFS_DAT)
  ) u_dec (
    .addr(req_addr),
    .hit (d_hit),
    .kind(d_kind),
    .cs  (d_cs)
  );

  // bus cycles only for NAND chip selects; reads only from the data register
  assign is_nand = d_hit && (cs_type[{d_cs, 1'b0} +: 2] == TYPE_NAND);
  assign go_bus  = is_nand && (req_write || (d_kind == RK_DAT));

  nacc_seq #(.CS_W(CS_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .req_size (req_size),
    .req_wdata(req_wdata),
    .go_bus   (go_bus),
    .kind     (d_kind),
    .cs       (d_cs),
    .wide     (cs_wide[d_cs]),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .dev_valid(dev_valid),
    .dev_ready(dev_ready),
    .dev_cs   (dev_cs),
    .dev_cle  (dev_cle),
    .dev_ale  (dev_ale),
    .dev_write(dev_write),
    .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata)
  );
endmodule

// File: rtl/nacc_checks.sv
`timescale 1ns/1ps
module nacc_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        dev_valid,
  input logic        dev_ready,
  input logic        dev_cle,
  input logic        dev_ale,
  input logic        dev_write,
  input logic [15:0] dev_wdata
);
  assert_one_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid |-> !(dev_cle && dev_ale));

  assert_read_plain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && !dev_write) |-> (!dev_cle && !dev_ale));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && !dev_ready) |=> (dev_valid && $stable(dev_wdata) && $stable(dev_cle)
                                   && $stable(dev_ale) && $stable(dev_write)));

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid || rsp_valid) |-> !req_ready);

  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind nand_access_adapter nacc_checks u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .dev_valid(dev_valid),
  .dev_ready(dev_ready),
  .dev_cle  (dev_cle),
  .dev_ale  (dev_ale),
  .dev_write(dev_write),
  .dev_wdata(dev_wdata)
);

// File: tb/nand_access_adapter_test.sv
`timescale 1ns/1ps
module nand_access_adapter_test;
  localparam int NUM_CS = 8;
  localparam int ADDR_W = 12;
  localparam int CS_W   = 3;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [2*NUM_CS-1:0] cs_type;
  logic [NUM_CS-1:0]   cs_wide;
  logic                req_valid = 1'b0, req_write = 1'b0;
  logic                req_ready;
  logic [ADDR_W-1:0]   req_addr = '0;
  logic [1:0]          req_size = '0;
  logic [31:0]         req_wdata = '0;
  logic                rsp_valid;
  logic [31:0]         rsp_rdata;
  logic                dev_valid, dev_cle, dev_ale, dev_write;
  logic                dev_ready = 1'b0;
  logic [CS_W-1:0]     dev_cs;
  logic [15:0]         dev_wdata;
  logic [15:0]         dev_rdata = '0;

  always #10 clk = ~clk;

  nand_access_adapter uut (
    .clk(clk), .rst_n(rst_n), .cs_type(cs_type), .cs_wide(cs_wide),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_cs(dev_cs),
    .dev_cle(dev_cle), .dev_ale(dev_ale), .dev_write(dev_write),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic        wr;
    logic [11:0] addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [2:0]  nb;
    logic        cle;
    logic        ale;
    logic [2:0]  cs;
    logic [15:0] b0;
    logic [15:0] bl;
    logic [31:0] rd;
  } vec_t;

  // Chip select map: cs0 NAND 8-bit, cs1 NAND 16-bit, cs2 type 0, cs3 type 1, cs7 NAND 16-bit.
  // Device read model: cycle k returns 16'hB1A0 + k*16'h0101.
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{4'd3, 1'b1, 12'h07c, 2'd0, 32'h000000A5, 3'd1, 1'b1, 1'b0, 3'd0, 16'h00A5, 16'h00A5, 32'h0},        // R3 command
    '{4'd4, 1'b1, 12'h080, 2'd2, 32'h44332211, 3'd4, 1'b0, 1'b1, 3'd0, 16'h0011, 16'h0044, 32'h0},        // R4 address word
    '{4'd4, 1'b1, 12'h084, 2'd1, 32'h0000BEEF, 3'd2, 1'b0, 1'b0, 3'd0, 16'h00EF, 16'h00BE, 32'h0},        // R4 data half
    '{4'd6, 1'b0, 12'h084, 2'd2, 32'h0,        3'd4, 1'b0, 1'b0, 3'd0, 16'h0,    16'h0,    32'hA3A2A1A0}, // R6
    '{4'd6, 1'b0, 12'h086, 2'd1, 32'h0,        3'd2, 1'b0, 1'b0, 3'd0, 16'h0,    16'h0,    32'h0000A1A0}, // R6
    '{4'd1, 1'b0, 12'h087, 2'd0, 32'h0,        3'd1, 1'b0, 1'b0, 3'd0, 16'h0,    16'h0,    32'h000000A0}, // R1 byte lane
    '{4'd5, 1'b1, 12'h0ac, 2'd2, 32'h12345678, 3'd2, 1'b1, 1'b0, 3'd1, 16'h5678, 16'h1234, 32'h0},        // R5 word
    '{4'd5, 1'b1, 12'h0b4, 2'd0, 32'h0000CDAB, 3'd1, 1'b0, 1'b0, 3'd1, 16'hCDAB, 16'hCDAB, 32'h0},        // R5 byte
    '{4'd5, 1'b1, 12'h0b4, 2'd1, 32'h0000CAFE, 3'd1, 1'b0, 1'b0, 3'd1, 16'hCAFE, 16'hCAFE, 32'h0},        // R5 half
    '{4'd6, 1'b0, 12'h0b4, 2'd2, 32'h0,        3'd2, 1'b0, 1'b0, 3'd1, 16'h0,    16'h0,    32'hB2A1B1A0}, // R6
    '{4'd6, 1'b0, 12'h0b4, 2'd0, 32'h0,        3'd1, 1'b0, 1'b0, 3'd1, 16'h0,    16'h0,    32'h000000A0}, // R6
    '{4'd6, 1'b0, 12'h0b4, 2'd1, 32'h0,        3'd1, 1'b0, 1'b0, 3'd1, 16'h0,    16'h0,    32'h0000B1A0}, // R6
    '{4'd2, 1'b1, 12'h0e4, 2'd2, 32'hFFFFFFFF, 3'd0, 1'b0, 1'b0, 3'd0, 16'h0,    16'h0,    32'h0},        // R2
    '{4'd2, 1'b0, 12'h0e4, 2'd2, 32'h0,        3'd0, 1'b0, 1'b0, 3'd0, 16'h0,    16'h0,    32'h0},        // R2
    '{4'd2, 1'b1, 12'h10c, 2'd0, 32'h00000055, 3'd0, 1'b0, 1'b0, 3'd0, 16'h0,    16'h0,    32'h0},        // R2
    '{4'd9, 1'b0, 12'h07c, 2'd2, 32'h0,        3'd0, 1'b0, 1'b0, 3'd0, 16'h0,    16'h0,    32'h0},        // R9
    '{4'd9, 1'b1, 12'h060, 2'd2, 32'h12345678, 3'd0, 1'b0, 1'b0, 3'd0, 16'h0,    16'h0,    32'h0},        // R9
    '{4'd7, 1'b1, 12'h1d0, 2'd3, 32'hA1B2C3D4, 3'd2, 1'b0, 1'b1, 3'd7, 16'hC3D4, 16'hA1B2, 32'h0},        // R7
    '{4'd7, 1'b1, 12'h084, 2'd3, 32'h0A0B0C0D, 3'd4, 1'b0, 1'b0, 3'd0, 16'h000D, 16'h000A, 32'h0}         // R7
  };

  int n_chk = 0;
  int n_fail = 0;

  int          r_nb;
  logic        r_cle, r_ale, r_wr;
  logic [2:0]  r_cs;
  logic [15:0] r_b0, r_bl;
  logic [31:0] r_rd;
  bit          r_lat_ok, r_rdy_ok, r_hold_ok, r_attr_ok;

  task automatic chk(input bit ok, input int tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input bit stall);
    int last_hs;
    bit got, seen, held;
    logic [15:0] h_wd;
    logic h_cle, h_ale;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    r_rdy_ok = req_ready;
    @(negedge clk);
    req_valid = 1'b0;
    r_nb = 0; last_hs = -1; got = 0; seen = 0; held = 0;
    r_lat_ok = 0; r_hold_ok = 1; r_attr_ok = 1; r_rd = 32'hDEAD_BEEF;
    r_b0 = '0; r_bl = '0; r_cle = 0; r_ale = 0; r_wr = 0; r_cs = '0;
    for (int c = 0; c < 24 && !got; c++) begin
      if (req_ready) r_rdy_ok = 0;
      if (held) begin
        if (!dev_valid || dev_wdata != h_wd || dev_cle != h_cle || dev_ale != h_ale) r_hold_ok = 0;
        held = 0;
      end
      if (rsp_valid) begin
        got = 1;
        r_rd = rsp_rdata;
        r_lat_ok = (c == last_hs + 1);
      end else if (dev_valid) begin
        dev_ready = stall ? (c % 2 == 1) : 1'b1;
        dev_rdata = 16'hB1A0 + 16'(r_nb) * 16'h0101;
        if (!seen) begin
          seen = 1; r_cle = dev_cle; r_ale = dev_ale; r_wr = dev_write; r_cs = dev_cs;
        end else if (dev_cle != r_cle || dev_ale != r_ale || dev_write != r_wr || dev_cs != r_cs) begin
          r_attr_ok = 0;
        end
        if (dev_ready) begin
          if (r_nb == 0) r_b0 = dev_wdata;
          r_bl = dev_wdata;
          r_nb++;
          last_hs = c;
        end else begin
          held = 1; h_wd = dev_wdata; h_cle = dev_cle; h_ale = dev_ale;
        end
      end else begin
        dev_ready = 1'b0;
      end
      if (!got) @(negedge clk);
    end
    dev_ready = 1'b0;
  endtask

  task automatic check_vec(input vec_t v, input bit stall);
    access(v.wr, v.addr, v.size, v.wdata, stall);
    chk(r_nb == int'(v.nb), v.tag, "device cycle count", 32'(r_nb), 32'(v.nb));
    if (v.nb != 0) begin
      chk(r_cle == v.cle && r_ale == v.ale, v.tag, "latch pins {cle,ale}",
          {30'h0, r_cle, r_ale}, {30'h0, v.cle, v.ale});
      chk(r_cs == v.cs, v.tag, "dev_cs (R1)", 32'(r_cs), 32'(v.cs));
      chk(r_wr == v.wr, v.tag, "dev_write", 32'(r_wr), 32'(v.wr));
      chk(r_attr_ok, v.tag, "attributes constant over cycles", 32'(r_attr_ok), 32'd1);
    end
    if (v.wr && v.nb != 0) begin
      chk(r_b0 == v.b0, v.tag, "first cycle data", 32'(r_b0), 32'(v.b0));
      chk(r_bl == v.bl, v.tag, "last cycle data", 32'(r_bl), 32'(v.bl));
    end
    chk(r_rd == v.rd, v.tag, "response data", r_rd, v.rd);
    // R8: response lands one cycle after the final handshake (or after acceptance)
    chk(r_lat_ok, 8, "response timing", 32'(r_lat_ok), 32'd1);
    chk(r_rdy_ok, 8, "req_ready idle-only", 32'(r_rdy_ok), 32'd1);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    cs_type = {2'd2, 2'd0, 2'd0, 2'd0, 2'd1, 2'd0, 2'd2, 2'd2};
    cs_wide = 8'b1000_0010;
    repeat (3) @(negedge clk);
    // R10: outputs idle during reset
    chk(req_ready && !dev_valid && !rsp_valid, 10, "reset state",
        {29'h0, req_ready, dev_valid, rsp_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !dev_valid && !rsp_valid, 10, "after reset",
        {29'h0, req_ready, dev_valid, rsp_valid}, 32'h4);

    for (int i = 0; i < NV; i++) check_vec(VECS[i], 1'b0);

    // R8: stalled device, pending cycle must hold still
    check_vec(VECS[1], 1'b1);
    chk(r_hold_ok, 8, "cycle held during stall (8-bit)", 32'(r_hold_ok), 32'd1);
    check_vec(VECS[9], 1'b1);
    chk(r_hold_ok, 8, "cycle held during stall (16-bit read)", 32'(r_hold_ok), 32'd1);

    // R10: reset in the middle of a device access
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h084; req_size = 2'd2; req_wdata = 32'h01020304;
    @(negedge clk);
    req_valid = 1'b0;
    chk(dev_valid, 10, "access started before reset", 32'(dev_valid), 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready && !dev_valid && !rsp_valid, 10, "reset mid-access",
        {29'h0, req_ready, dev_valid, rsp_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    check_vec(VECS[0], 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule